// File: doc/BRIEF.md
# Low-Side Inverter Fault Protection Controller

This block guards the three low-side switches of a three-phase inverter bridge. It receives comparator flags that have already been digitised: short circuit, overcurrent and control-supply undervoltage. It also receives the gate commands for both the high side and the low side.

The two current flags are qualified separately. Each must stay high for its own run of consecutive clock cycles before it counts as a trip. A qualified current trip does two things at once. It removes every low-side gate enable, and it pulls the active-low fault line down for a fixed number of cycles. After that pulse the low-side gates stay blocked until the low-side commands are seen all off. An undervoltage condition is handled differently: it blocks the low side and holds the fault line low only for as long as the flag is present.

The high-side commands pass straight through. A one-cycle event strobe and a 2-bit cause code record each trip that is logged.

Top module: `lsp_fault_ctrl`

## Requirements
- R1: A short-circuit trip happens on the SC_QUAL-th consecutive clock edge at which `sc_flag` is high, and not earlier.
- R2: An overcurrent trip happens on the OC_QUAL-th consecutive clock edge at which `oc_flag` is high, and not earlier.
- R3: If a current flag is low at any clock edge, its qualification count restarts from zero. A broken run therefore never trips, whatever its total length.
- R4: From the cycle that follows a qualifying edge, `fault_n` is 0 and all bits of `ls_gate` are 0.
- R5: A current trip holds `fault_n` low for exactly PULSE_LEN cycles. A further current trip that qualifies during the pulse neither lengthens the pulse nor logs a new event.
- R6: When the pulse ends, `fault_n` returns to 1. `ls_gate` stays all 0 until a clock edge at which `ls_cmd` is all zero. From the next cycle on, `ls_gate` follows `ls_cmd` again.
- R7: While `uv_flag` is 1, `fault_n` is 0 and `ls_gate` is all 0 in the same cycle. When `uv_flag` falls, both are released at once, provided no current fault is active.
- R8: `hs_gate` always equals `hs_cmd`.
- R9: A logged event raises `trip_evt` for exactly one cycle and updates `trip_cause`. The codes are 2'b01 for overcurrent, 2'b10 for short circuit and 2'b11 for an undervoltage rising edge. If more than one cause is present in the same cycle, one event is logged, chosen in the order short circuit, then overcurrent, then undervoltage.
- R10: After reset, `fault_n` is 1, `trip_evt` is 0, `trip_cause` is 2'b00, and `ls_gate` follows `ls_cmd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sc_flag | input | 1 | Short-circuit comparator flag |
| oc_flag | input | 1 | Overcurrent comparator flag |
| uv_flag | input | 1 | Control-supply undervoltage flag |
| hs_cmd | input | NPH | High-side gate commands |
| ls_cmd | input | NPH | Low-side gate commands |
| hs_gate | output | NPH | High-side gate enables (pass-through) |
| ls_gate | output | NPH | Low-side gate enables after protection masking |
| fault_n | output | 1 | Active-low fault line |
| trip_evt | output | 1 | One-cycle strobe for each logged trip event |
| trip_cause | output | 2 | Cause of the most recent logged event |

## Verification
Two situations are hard to reach from the ports. The first is two trips arriving together. The bench starts the overcurrent run and then starts the short-circuit run exactly OC_QUAL minus SC_QUAL cycles later, so that both filters complete on the same edge. The second is a short circuit qualifying in the middle of an overcurrent pulse. For that case the bench counts every low cycle of `fault_n` and every event strobe until the line recovers. It then holds the low-side commands on to show that the block stays masked after the pulse, and drops them to release it.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_WAIT  = 2'd2
    } prot_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_OC   = 2'b01,
        CAUSE_SC   = 2'b10,
        CAUSE_UV   = 2'b11
    } cause_e;

    typedef struct packed {
        logic sc;
        logic oc;
        logic uv_rise;
    } trip_req_t;

    // Highest priority first: short circuit, overcurrent, undervoltage.
    function automatic cause_e pick_cause(input trip_req_t r);
        cause_e c;
        if (r.sc)
            c = CAUSE_SC;
        else if (r.oc)
            c = CAUSE_OC;
        else if (r.uv_rise)
            c = CAUSE_UV;
        else
            c = CAUSE_NONE;
        return c;
    endfunction

endpackage

// File: rtl/lsp_qual_filter.sv
module lsp_qual_filter #(
    parameter int QUAL = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic flag,
    output logic qual
);
    localparam int CW = $clog2(QUAL + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive high samples; any low sample restarts the run.
    always_ff @(posedge clk) begin
        if (rst)
            run_cnt <= '0;
        else if (!flag)
            run_cnt <= '0;
        else if (run_cnt != LAST)
            run_cnt <= run_cnt + 1'b1;
    end

    assign qual = flag && (run_cnt == LAST);

    AST_FILTER_RESTART: assert property (@(posedge clk) disable iff (rst)
        !flag |=> run_cnt == '0); // R3

    AST_QUAL_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        qual |-> $past(flag)); // R1

endmodule

// File: rtl/lsp_trip_fsm.sv
module lsp_trip_fsm
    import lsp_pkg::*;
#(
    parameter int NPH       = 3,
    parameter int PULSE_LEN = 360000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cur_trip,
    input  logic [NPH-1:0] ls_cmd,
    output prot_state_e    state,
    output logic           enter_pulse
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] PLAST = PW'(PULSE_LEN - 1);

    prot_state_e   nxt;
    logic [PW-1:0] pcnt;
    logic          all_off;

    assign all_off     = (ls_cmd == '0);
    // A new pulse starts only outside an active pulse.
    assign enter_pulse = cur_trip && (state != ST_PULSE);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (cur_trip) nxt = ST_PULSE;
            ST_PULSE: if (pcnt == PLAST) nxt = ST_WAIT;
            ST_WAIT: begin
                if (cur_trip)
                    nxt = ST_PULSE;
                else if (all_off)
                    nxt = ST_IDLE;
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pcnt  <= '0;
        end else begin
            state <= nxt;
            if (enter_pulse)
                pcnt <= '0;
            else if (state == ST_PULSE && pcnt != PLAST)
                pcnt <= pcnt + 1'b1;
        end
    end

    AST_PULSE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PULSE && pcnt != PLAST) |=>
            (state == ST_PULSE && (pcnt - $past(pcnt)) == PW'(1))); // R5

    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PULSE && pcnt == PLAST) |=> state == ST_WAIT); // R5

    AST_HOLD_UNTIL_OFF: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !all_off && !cur_trip) |=> state == ST_WAIT); // R6

endmodule

// File: rtl/lsp_event_log.sv
module lsp_event_log
    import lsp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sc_q,
    input  logic   oc_q,
    input  logic   enter_pulse,
    input  logic   uv_flag,
    output logic   trip_evt,
    output cause_e cause
);
    logic      uv_prev;
    trip_req_t req;

    always_comb begin
        req.sc      = sc_q && enter_pulse;
        req.oc      = oc_q && enter_pulse;
        req.uv_rise = uv_flag && !uv_prev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            uv_prev  <= 1'b0;
            trip_evt <= 1'b0;
            cause    <= CAUSE_NONE;
        end else begin
            uv_prev <= uv_flag;
            if (req != '0) begin
                trip_evt <= 1'b1;
                cause    <= pick_cause(req);
            end else begin
                trip_evt <= 1'b0;
            end
        end
    end

    AST_EVT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        trip_evt |-> cause != CAUSE_NONE); // R9

    AST_SC_WINS: assert property (@(posedge clk) disable iff (rst)
        (sc_q && enter_pulse) |=> (trip_evt && cause == CAUSE_SC)); // R9

endmodule

// File: rtl/lsp_gate_mask.sv
module lsp_gate_mask #(
    parameter int NPH = 3
) (
    input  logic [NPH-1:0] hs_cmd,
    input  logic [NPH-1:0] ls_cmd,
    input  logic           block,
    output logic [NPH-1:0] hs_gate,
    output logic [NPH-1:0] ls_gate
);
    for (genvar i = 0; i < NPH; i++) begin : g_phase
        assign hs_gate[i] = hs_cmd[i];
        assign ls_gate[i] = ls_cmd[i] & ~block;
    end
endmodule

// File: rtl/lsp_fault_ctrl.sv
module lsp_fault_ctrl
    import lsp_pkg::*;
#(
    parameter int NPH       = 3,
    parameter int SC_QUAL   = 400,
    parameter int OC_QUAL   = 2000,
    parameter int PULSE_LEN = 360000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sc_flag,
    input  logic           oc_flag,
    input  logic           uv_flag,
    input  logic [NPH-1:0] hs_cmd,
    input  logic [NPH-1:0] ls_cmd,
    output logic [NPH-1:0] hs_gate,
    output logic [NPH-1:0] ls_gate,
    output logic           fault_n,
    output logic           trip_evt,
    output logic [1:0]     trip_cause
);
    logic        sc_q;
    logic        oc_q;
    logic        enter_pulse;
    logic        block;
    prot_state_e state;
    cause_e      cause;

    lsp_qual_filter #(.QUAL(SC_QUAL)) u_sc_filt (
        .clk  (clk),
        .rst  (rst),
        .flag (sc_flag),
        .qual (sc_q)
    );

    lsp_qual_filter #(.QUAL(OC_QUAL)) u_oc_filt (
        .clk  (clk),
        .rst  (rst),
        .flag (oc_flag),
        .qual (oc_q)
    );

    lsp_trip_fsm #(.NPH(NPH), .PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cur_trip    (sc_q | oc_q),
        .ls_cmd      (ls_cmd),
        .state       (state),
        .enter_pulse (enter_pulse)
    );

    lsp_event_log u_log (
        .clk         (clk),
        .rst         (rst),
        .sc_q        (sc_q),
        .oc_q        (oc_q),
        .enter_pulse (enter_pulse),
        .uv_flag     (uv_flag),
        .trip_evt    (trip_evt),
        .cause       (cause)
    );

    assign block      = (state != ST_IDLE) || uv_flag;
    assign fault_n    = !((state == ST_PULSE) || uv_flag);
    assign trip_cause = cause;

    lsp_gate_mask #(.NPH(NPH)) u_mask (
        .hs_cmd  (hs_cmd),
        .ls_cmd  (ls_cmd),
        .block   (block),
        .hs_gate (hs_gate),
        .ls_gate (ls_gate)
    );

    AST_FAULT_BLOCKS_LS: assert property (@(posedge clk) disable iff (rst)
        !fault_n |-> ls_gate == '0); // R4

    AST_UV_HOLDS: assert property (@(posedge clk) disable iff (rst)
        uv_flag |-> (!fault_n && ls_gate == '0)); // R7

    AST_HS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        hs_gate == hs_cmd); // R8

    AST_TRIP_MASKS: assert property (@(posedge clk) disable iff (rst)
        enter_pulse |=> (!fault_n && ls_gate == '0)); // R4

endmodule

// File: tb/tb_lsp_fault_ctrl.sv
module tb_lsp_fault_ctrl;
    localparam int NPH = 3;
    localparam int SCQ = 3;
    localparam int OCQ = 7;
    localparam int PL  = 12;
    localparam int NV  = 8;

    // {uv, hs[2:0], ls[2:0], exp_fault_n, exp_ls[2:0]}
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 3'b101, 3'b010, 1'b1, 3'b010},
        {1'b0, 3'b010, 3'b101, 1'b1, 3'b101},
        {1'b1, 3'b111, 3'b111, 1'b0, 3'b000},
        {1'b1, 3'b000, 3'b011, 1'b0, 3'b000},
        {1'b0, 3'b110, 3'b011, 1'b1, 3'b011},
        {1'b0, 3'b001, 3'b100, 1'b1, 3'b100},
        {1'b1, 3'b011, 3'b000, 1'b0, 3'b000},
        {1'b0, 3'b111, 3'b111, 1'b1, 3'b111}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           sc_flag = 1'b0;
    logic           oc_flag = 1'b0;
    logic           uv_flag = 1'b0;
    logic [NPH-1:0] hs_cmd = '0;
    logic [NPH-1:0] ls_cmd = '0;
    logic [NPH-1:0] hs_gate;
    logic [NPH-1:0] ls_gate;
    logic           fault_n;
    logic           trip_evt;
    logic [1:0]     trip_cause;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    lsp_fault_ctrl #(
        .NPH(NPH), .SC_QUAL(SCQ), .OC_QUAL(OCQ), .PULSE_LEN(PL)
    ) dut (
        .clk(clk), .rst(rst),
        .sc_flag(sc_flag), .oc_flag(oc_flag), .uv_flag(uv_flag),
        .hs_cmd(hs_cmd), .ls_cmd(ls_cmd),
        .hs_gate(hs_gate), .ls_gate(ls_gate),
        .fault_n(fault_n), .trip_evt(trip_evt), .trip_cause(trip_cause)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clear the flags, wait for the pulse to end, then drop and restore the commands.
    task automatic release_all();
        sc_flag = 1'b0;
        oc_flag = 1'b0;
        uv_flag = 1'b0;
        for (int i = 0; i < PL + 2; i++) begin
            #1;
            if (fault_n) break;
            adv(1);
        end
        ls_cmd = '0;
        adv(1);
        ls_cmd = '1;
        #1;
    endtask

    initial begin
        int lowcnt;
        int evtcnt;

        adv(3);
        rst = 1'b0;
        ls_cmd = 3'b110;
        hs_cmd = 3'b011;
        #1;
        check("R10 fault_n", fault_n, 1);
        check("R10 trip_evt", trip_evt, 0);
        check("R10 trip_cause", trip_cause, 0);
        check("R10 ls_gate", ls_gate, 3'b110);

        // Table: undervoltage and pass-through patterns (R7, R8).
        for (int v = 0; v < NV; v++) begin
            adv(1);
            uv_flag = VEC[v][10];
            hs_cmd  = VEC[v][9:7];
            ls_cmd  = VEC[v][6:4];
            #1;
            check("R7 fault_n", fault_n, VEC[v][3]);
            check("R7 ls_gate", ls_gate, VEC[v][2:0]);
            check("R8 hs_gate", hs_gate, VEC[v][9:7]);
        end

        // R9: an undervoltage rising edge logs cause 11.
        adv(1);
        uv_flag = 1'b1;
        adv(1);
        #1;
        check("R9 uv evt", trip_evt, 1);
        check("R9 uv cause", trip_cause, 2'b11);
        uv_flag = 1'b0;
        #1;
        check("R7 uv release", fault_n, 1);
        adv(2);

        // R1/R4/R5/R6: short-circuit trip and the full release sequence.
        ls_cmd  = '1;
        sc_flag = 1'b1;
        adv(SCQ - 1);
        #1;
        check("R1 no early trip", fault_n, 1);
        adv(1);
        #1;
        check("R1 trip", fault_n, 0);
        check("R4 ls blocked", ls_gate, 0);
        check("R9 sc evt", trip_evt, 1);
        check("R9 sc cause", trip_cause, 2'b10);
        sc_flag = 1'b0;
        lowcnt = 1;
        for (int j = 1; j < PL; j++) begin
            adv(1);
            #1;
            if (!fault_n) lowcnt++;
            if (j == 1) check("R9 evt one cycle", trip_evt, 0);
        end
        check("R5 pulse length", lowcnt, PL);
        adv(1);
        #1;
        check("R6 pulse over", fault_n, 1);
        check("R6 still blocked", ls_gate, 0);
        adv(2);
        #1;
        check("R6 held while on", ls_gate, 0);
        ls_cmd = '0;
        adv(1);
        ls_cmd = 3'b101;
        #1;
        check("R6 released", ls_gate, 3'b101);
        ls_cmd = '1;

        // R3: a broken short-circuit run does not trip.
        adv(1);
        sc_flag = 1'b1;
        adv(SCQ - 1);
        sc_flag = 1'b0;
        adv(1);
        sc_flag = 1'b1;
        adv(SCQ - 1);
        #1;
        check("R3 broken run", fault_n, 1);
        adv(1);
        #1;
        check("R3 full run trips", fault_n, 0);
        release_all();

        // R2/R5: overcurrent trip, short circuit qualifying inside the pulse.
        adv(1);
        oc_flag = 1'b1;
        adv(OCQ - 1);
        #1;
        check("R2 no early trip", fault_n, 1);
        adv(1);
        #1;
        check("R2 trip", fault_n, 0);
        check("R9 oc cause", trip_cause, 2'b01);
        oc_flag = 1'b0;
        sc_flag = 1'b1;
        lowcnt = 1;
        evtcnt = 0;
        for (int i = 0; i < PL + 4; i++) begin
            adv(1);
            if (i == SCQ + 1) sc_flag = 1'b0;
            #1;
            if (!fault_n) lowcnt++;
            if (trip_evt) evtcnt++;
        end
        check("R5 no restart", lowcnt, PL);
        check("R5 no new event", evtcnt, 0);
        release_all();

        // R9: both filters complete on the same edge.
        adv(1);
        oc_flag = 1'b1;
        adv(OCQ - SCQ);
        sc_flag = 1'b1;
        adv(SCQ - 1);
        #1;
        check("R9 before joint trip", fault_n, 1);
        adv(1);
        #1;
        check("R9 joint evt", trip_evt, 1);
        check("R9 joint cause", trip_cause, 2'b10);
        sc_flag = 1'b0;
        oc_flag = 1'b0;
        adv(1);
        #1;
        check("R9 single event", trip_evt, 0);
        release_all();
        check("R6 final pass", ls_gate, 3'b111);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule